// File: doc/BRIEF.md
# Configurable UART Framing Engine

This block holds a serial transmitter and a serial receiver that share one frame format, chosen by an 8-bit line-control word. The format covers how many data bits a frame carries (five to eight), whether a parity bit is present, whether that bit follows an even or odd count of ones or is pinned to a fixed level, and whether the transmitter ends each frame with one or two stop bits. Bit timing comes from an external strobe that pulses sixteen times per bit period; this block does not divide the clock itself.

Software-side traffic passes through two queues. In queue mode each direction buffers up to sixteen characters. In holding mode each direction keeps just one. Each received character is stored together with its own parity-error and framing-error flags, so the flags seen at the read port always belong to the character shown beside them. Writes to a full transmit queue and frames that arrive at a full receive queue are dropped.

Line-control bit map: bit 0 queue enable, bit 1 parity enable, bit 2 even select, bit 3 two stop bits, bits 5:4 data length (00 = 5, 01 = 6, 10 = 7, 11 = 8), bit 6 unused, bit 7 fixed-level parity.

Top module: `uart_frame_engine`

## Requirements
- R1: A transmitted frame is one low start bit, then the data bits LSB first (count set by bits 5:4: 00 = 5, 01 = 6, 10 = 7, 11 = 8), then an optional parity bit, then high stop level. Each bit lasts 16 ticks.
- R2: With bit 3 at 1 the transmitter holds two stop-bit periods (32 ticks) of high level before the next start bit. With bit 3 at 0 it holds one (16 ticks).
- R3: With bit 1 = 1 and bit 7 = 0, the parity bit makes the count of ones across data and parity even when bit 2 = 1, and odd when bit 2 = 0.
- R4: With bits 1 and 7 at 1, the parity bit is sent as 0 and checked against 0 when bit 2 = 1, and sent as 1 and checked against 1 when bit 2 = 0.
- R5: With bit 1 = 0, no parity bit is sent or expected, bits 2 and 7 have no effect, and the parity-error flag of a received character is 0.
- R6: A received parity bit that differs from the expected value sets the parity-error flag (rd_perr) stored with that character.
- R7: A first stop bit that samples low sets the framing-error flag (rd_ferr) stored with that character.
- R8: In two-stop mode the receiver samples only the first stop bit, so a low second stop bit leaves rd_ferr at 0.
- R9: The receiver takes a falling edge as a start bit only if the line is still low 8 ticks later. A shorter low pulse yields no character.
- R10: With bit 0 = 1, each queue holds 16 characters in order. The full flag rises at 16, a write to a full transmit queue is dropped, and a frame that arrives at a full receive queue is dropped.
- R11: With bit 0 = 0, each direction holds one character. The full flag rises at one, and further writes or arriving frames are dropped until the held character is taken.
- R12: After reset txd is high, both empty flags are 1 and both full flags are 0.
- R13: Received data bits above the selected data length read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| lcr | input | 8 | Line-control word (frame format and queue mode) |
| wr_data | input | 8 | Character to transmit |
| wr_en | input | 1 | Pushes wr_data into the transmit queue |
| tx_full | output | 1 | Transmit queue cannot accept a character |
| tx_empty | output | 1 | Transmit queue holds nothing |
| txd | output | 1 | Serial output line, idle high |
| rxd | input | 1 | Serial input line, idle high |
| rd_en | input | 1 | Removes the head character of the receive queue |
| rd_data | output | 8 | Head character of the receive queue |
| rd_perr | output | 1 | Parity-error flag stored with the head character |
| rd_ferr | output | 1 | Framing-error flag stored with the head character |
| rx_full | output | 1 | Receive queue cannot accept a frame |
| rx_empty | output | 1 | Receive queue holds nothing |

## Verification
The bench targets fixed-level parity in both polarities. A design that mixed up the polarity, or still applied even/odd rules, would send the wrong line level and would flag correctly formed frames. It also targets a low second stop bit in two-stop mode: a receiver that checked that bit would raise a false framing error. It measures the gap between start bits, because a wrong stop count shows up only in timing. It fills both queues to their limits in both modes: a queue with the wrong depth, or one that overwrote entries when full, would show up as lost, duplicated or reordered characters. Finally it sends a short low glitch, which a receiver that trusted the edge alone would turn into a phantom character.

// File: rtl/uart_fe_pkg.sv
// Shared types and helpers for the UART framing engine.
// Assumes a data path no wider than 8 bits and lengths of 5..8.
package uart_fe_pkg;

    // Frame-level state shared by transmitter and receiver.
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } fe_state_t;

    // Mask keeping only the low 5..8 data bits selected by the length code.
    function automatic logic [7:0] len_mask(input logic [1:0] len_code);
        return 8'hFF >> (2'd3 - len_code);
    endfunction

    // Index of the last data bit for a length code (4..7).
    function automatic logic [2:0] last_idx(input logic [1:0] len_code);
        return 3'd4 + {1'b0, len_code};
    endfunction

    // Parity bit for already-masked data: fixed level or even/odd count.
    function automatic logic parity_of(input logic even_sel, input logic fixed_sel,
                                       input logic [7:0] bits);
        logic p;
        if (fixed_sel)
            p = ~even_sel;
        else if (even_sel)
            p = ^bits;
        else
            p = ~(^bits);
        return p;
    endfunction

endpackage

// File: rtl/uart_fe_queue.sv
// Character queue used on both paths of the framing engine.
// In queue mode (one_deep = 0) it holds DEPTH entries; in holding mode it
// accepts a single entry. Writes when full and reads when empty are ignored.
// Output shows the head entry combinationally. Assumes DEPTH >= 2.
module uart_fe_queue #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             one_deep,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    // Flags and accepted-operation qualifiers.
    always_comb begin
        empty   = (count == '0);
        full    = one_deep ? (count != '0) : (count == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rptr];
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count)); // R10
    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (one_deep && count <= 1 && !($past(one_deep) == 1'b0 && count > 1))
        |=> (count <= 1 || !one_deep)); // R11
    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R10

endmodule

// File: rtl/uart_fe_tx.sv
// Serial transmitter of the framing engine.
// Takes a character from its queue whenever idle, latches the frame format
// at that moment, and shifts start, data (LSB first), optional parity and
// one or two stop bits. Each bit lasts OSR ticks of the oversampling strobe.
module uart_fe_tx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_even,
    input  logic       cfg_fixed,
    input  logic       cfg_two_stop,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       txd
);
    import uart_fe_pkg::*;

    localparam int CNT_W = $clog2(OSR);

    fe_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_i;
    logic [2:0]       last_i;
    logic [7:0]       shreg;
    logic             pbit;
    logic             par_on;
    logic             two_stop;
    logic             fixed_q;
    logic             even_q;
    logic             stop_i;
    logic [7:0]       masked;
    logic             bit_end;

    // Load request and per-bit boundary detection.
    always_comb begin
        q_pop   = (st == S_IDLE) && !q_empty;
        masked  = q_data & len_mask(cfg_len);
        bit_end = tick && (cnt == CNT_W'(OSR - 1));
    end

    // Frame sequencer and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            txd      <= 1'b1;
            cnt      <= '0;
            bit_i    <= '0;
            last_i   <= '0;
            shreg    <= '0;
            pbit     <= 1'b0;
            par_on   <= 1'b0;
            two_stop <= 1'b0;
            fixed_q  <= 1'b0;
            even_q   <= 1'b0;
            stop_i   <= 1'b0;
        end else if (st == S_IDLE) begin
            txd <= 1'b1;
            if (!q_empty) begin
                st       <= S_START;
                txd      <= 1'b0;
                cnt      <= '0;
                shreg    <= masked;
                last_i   <= last_idx(cfg_len);
                pbit     <= parity_of(cfg_even, cfg_fixed, masked);
                par_on   <= cfg_par_en;
                two_stop <= cfg_two_stop;
                fixed_q  <= cfg_fixed;
                even_q   <= cfg_even;
            end
        end else if (tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
            if (bit_end) begin
                case (st)
                    S_START: begin
                        st    <= S_DATA;
                        bit_i <= '0;
                        txd   <= shreg[0];
                        shreg <= shreg >> 1;
                    end
                    S_DATA: begin
                        if (bit_i == last_i) begin
                            stop_i <= 1'b0;
                            if (par_on) begin
                                st  <= S_PAR;
                                txd <= pbit;
                            end else begin
                                st  <= S_STOP;
                                txd <= 1'b1;
                            end
                        end else begin
                            bit_i <= bit_i + 1'b1;
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                        end
                    end
                    S_PAR: begin
                        st  <= S_STOP;
                        txd <= 1'b1;
                    end
                    S_STOP: begin
                        if (stop_i == two_stop)
                            st <= S_IDLE;
                        else
                            stop_i <= 1'b1;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> txd); // R12
    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_START) |-> !txd); // R1
    AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STOP) |-> txd); // R2
    AST_TX_FIXED_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PAR && fixed_q) |-> (txd == !even_q)); // R4

endmodule

// File: rtl/uart_fe_rx.sv
// Serial receiver of the framing engine.
// Synchronises the line, treats a falling edge as a candidate start bit,
// confirms it half a bit later, then samples every later bit at its middle.
// Only the first stop bit is examined. Emits a one-cycle push carrying the
// data and its parity and framing flags. Format is latched at start confirm.
module uart_fe_rx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_even,
    input  logic       cfg_fixed,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] push_data,
    output logic       push_perr,
    output logic       push_ferr
);
    import uart_fe_pkg::*;

    localparam int CNT_W = $clog2(OSR);
    localparam int HALF  = OSR / 2;

    fe_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_i;
    logic [2:0]       last_i;
    logic [7:0]       shreg;
    logic             par_on;
    logic             even_q;
    logic             fixed_q;
    logic             perr;
    logic             sync1;
    logic             sync2;
    logic             line_prev;
    logic             fall;
    logic             mid_bit;

    // Two-stage synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1     <= 1'b1;
            sync2     <= 1'b1;
            line_prev <= 1'b1;
        end else begin
            sync1     <= rxd;
            sync2     <= sync1;
            line_prev <= sync2;
        end
    end

    // Edge and sample-point detection.
    always_comb begin
        fall    = line_prev && !sync2;
        mid_bit = tick && (cnt == CNT_W'(OSR - 1));
    end

    // Frame sequencer, sampler and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            cnt       <= '0;
            bit_i     <= '0;
            last_i    <= '0;
            shreg     <= '0;
            par_on    <= 1'b0;
            even_q    <= 1'b0;
            fixed_q   <= 1'b0;
            perr      <= 1'b0;
            push      <= 1'b0;
            push_data <= '0;
            push_perr <= 1'b0;
            push_ferr <= 1'b0;
        end else begin
            push <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (fall) begin
                        st  <= S_START;
                        cnt <= '0;
                    end
                end
                S_START: begin
                    if (tick) begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            cnt <= '0;
                            if (!sync2) begin
                                st      <= S_DATA;
                                bit_i   <= '0;
                                shreg   <= '0;
                                perr    <= 1'b0;
                                last_i  <= last_idx(cfg_len);
                                par_on  <= cfg_par_en;
                                even_q  <= cfg_even;
                                fixed_q <= cfg_fixed;
                            end else begin
                                st <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (tick) begin
                        cnt <= mid_bit ? '0 : cnt + 1'b1;
                        if (mid_bit) begin
                            shreg[bit_i] <= sync2;
                            if (bit_i == last_i)
                                st <= par_on ? S_PAR : S_STOP;
                            else
                                bit_i <= bit_i + 1'b1;
                        end
                    end
                end
                S_PAR: begin
                    if (tick) begin
                        cnt <= mid_bit ? '0 : cnt + 1'b1;
                        if (mid_bit) begin
                            perr <= (sync2 != parity_of(even_q, fixed_q, shreg));
                            st   <= S_STOP;
                        end
                    end
                end
                S_STOP: begin
                    if (tick) begin
                        cnt <= mid_bit ? '0 : cnt + 1'b1;
                        if (mid_bit) begin
                            push      <= 1'b1;
                            push_data <= shreg;
                            push_perr <= perr;
                            push_ferr <= !sync2;
                            st        <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_START_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DATA && $past(st) == S_START) |-> !$past(sync2)); // R9
    AST_NO_PAR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !par_on) |-> !push_perr); // R5
    AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R7

endmodule

// File: rtl/uart_frame_engine.sv
// Top of the UART framing engine: decodes the line-control word and joins
// a transmit queue, a receive queue, the transmitter and the receiver.
// Line-control layout: [0] queue enable, [1] parity enable, [2] even
// select, [3] two stop bits, [5:4] data length code, [6] unused,
// [7] fixed-level parity. The format should change only between frames.
module uart_frame_engine #(
    parameter int QDEPTH = 16,
    parameter int OSR    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic [7:0] lcr,
    input  logic [7:0] wr_data,
    input  logic       wr_en,
    output logic       tx_full,
    output logic       tx_empty,
    output logic       txd,
    input  logic       rxd,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rx_full,
    output logic       rx_empty
);
    localparam int RXW = 10;

    logic       one_deep;
    logic       lcr_unused;
    logic       txq_pop;
    logic [7:0] txq_data;
    logic       rx_push;
    logic [7:0] rx_pdata;
    logic       rx_pperr;
    logic       rx_pferr;
    logic [RXW-1:0] rxq_dout;

    // Line-control decode shared by both paths.
    always_comb begin
        one_deep   = !lcr[0];
        lcr_unused = lcr[6];
        rd_data    = rxq_dout[7:0];
        rd_perr    = rxq_dout[8];
        rd_ferr    = rxq_dout[9];
    end

    uart_fe_queue #(.WIDTH(8), .DEPTH(QDEPTH)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .one_deep (one_deep),
        .push     (wr_en),
        .din      (wr_data),
        .pop      (txq_pop),
        .dout     (txq_data),
        .empty    (tx_empty),
        .full     (tx_full)
    );

    uart_fe_tx #(.OSR(OSR)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .cfg_len      (lcr[5:4]),
        .cfg_par_en   (lcr[1]),
        .cfg_even     (lcr[2]),
        .cfg_fixed    (lcr[7]),
        .cfg_two_stop (lcr[3]),
        .q_empty      (tx_empty),
        .q_data       (txq_data),
        .q_pop        (txq_pop),
        .txd          (txd)
    );

    uart_fe_rx #(.OSR(OSR)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .cfg_len    (lcr[5:4]),
        .cfg_par_en (lcr[1]),
        .cfg_even   (lcr[2]),
        .cfg_fixed  (lcr[7]),
        .rxd        (rxd),
        .push       (rx_push),
        .push_data  (rx_pdata),
        .push_perr  (rx_pperr),
        .push_ferr  (rx_pferr)
    );

    uart_fe_queue #(.WIDTH(RXW), .DEPTH(QDEPTH)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .one_deep (one_deep),
        .push     (rx_push),
        .din      ({rx_pferr, rx_pperr, rx_pdata}),
        .pop      (rd_en),
        .dout     (rxq_dout),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(!rst_n) |-> (txd && tx_empty && rx_empty && !tx_full && !rx_full)); // R12

endmodule

// File: tb/sim_uart_frame_engine.sv
// Bench: table of format/data vectors sent in loopback, then directed tests.
module sim_uart_frame_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [7:0] lcr = 8'h31;
    logic [7:0] wr_data = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       loop = 1'b1;
    logic       drv = 1'b1;
    logic       tx_full, tx_empty, txd, rd_perr, rd_ferr, rx_full, rx_empty;
    logic [7:0] rd_data;
    wire        rxd = loop ? txd : drv;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Vectors: {lcr, data}. lcr bits: [0] queue, [1] parity, [2] even,
    // [3] two stop, [5:4] length code, [7] fixed parity.
    localparam logic [15:0] VECS [0:7] = '{
        16'h31A5,  // R1 8 bits, no parity
        16'h373C,  // R3 8 bits, even
        16'h333C,  // R3 8 bits, odd
        16'h2FD5,  // R3 R13 7 bits, even, two stop
        16'h03FF,  // R13 5 bits, odd
        16'h972B,  // R4 6 bits, fixed 0
        16'hB300,  // R4 8 bits, fixed 1
        16'hB581   // R5 parity off, even and fixed set
    };

    uart_frame_engine u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .lcr(lcr),
        .wr_data(wr_data), .wr_en(wr_en), .tx_full(tx_full), .tx_empty(tx_empty),
        .txd(txd), .rxd(rxd), .rd_en(rd_en), .rd_data(rd_data),
        .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rx_full(rx_full), .rx_empty(rx_empty)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    initial forever begin @(negedge clk); tick16 = ~tick16; end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_data = b; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_rx();
        int n = 0;
        while (rx_empty && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic take(output logic [7:0] d, output logic pe, output logic fe);
        @(negedge clk);
        d = rd_data; pe = rd_perr; fe = rd_ferr;
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // Drives one frame on rxd at 32 clocks (16 ticks) per bit.
    task automatic drive(input logic [7:0] d, input int nb, input bit hp, input bit pv,
                         input bit s1, input bit two, input bit s2);
        loop = 1'b0;
        @(negedge clk); drv = 1'b0; repeat (32) @(negedge clk);
        for (int i = 0; i < nb; i++) begin drv = d[i]; repeat (32) @(negedge clk); end
        if (hp) begin drv = pv; repeat (32) @(negedge clk); end
        drv = s1; repeat (32) @(negedge clk);
        if (two) begin drv = s2; repeat (32) @(negedge clk); end
        drv = 1'b1; repeat (64) @(negedge clk);
    endtask

    // Captures one frame from txd at bit centres and compares with the
    // frame computed from the requirements.
    task automatic capture(input logic [7:0] lv, input logic [7:0] d, input string req);
        logic [11:0] e = '0;
        logic [11:0] c = '0;
        int nb = 5 + int'(lv[5:4]);
        logic [7:0] m = d & (8'hFF >> (3 - int'(lv[5:4])));
        logic par = lv[7] ? !lv[2] : (lv[2] ? ^m : ~^m);
        int n = 1;
        for (int i = 0; i < nb; i++) begin e[n] = m[i]; n++; end
        if (lv[1]) begin e[n] = par; n++; end
        e[n] = 1'b1; n++;
        if (lv[3]) begin e[n] = 1'b1; n++; end
        @(negedge txd);
        repeat (16) @(negedge clk);
        c[0] = txd;
        for (int k = 1; k < n; k++) begin repeat (32) @(negedge clk); c[k] = txd; end
        chk(c == e, req, {20'd0, c}, {20'd0, e});
    endtask

    // Measures the gap between two start bits of back-to-back 0xFF frames.
    task automatic gap(input logic [7:0] lv, input int expct, input string req);
        int t0 = 0, t1 = 0;
        lcr = lv;
        fork
            begin @(negedge txd); t0 = cyc; @(negedge txd); t1 = cyc; end
            begin put(8'hFF); put(8'hFF); end
        join
        chk(((t1 - t0) >= expct - 3) && ((t1 - t0) <= expct + 3), req, t1 - t0, expct);
        repeat (400) @(negedge clk);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic pe, fe;
        do_reset();
        // R12 reset state
        chk(txd == 1'b1, "R12 txd", txd, 1);
        chk(tx_empty && rx_empty, "R12 empty", {tx_empty, rx_empty}, 2'b11);
        chk(!tx_full && !rx_full, "R12 full", {tx_full, rx_full}, 0);

        // Table walk in loopback: line frame check, then received character.
        for (int v = 0; v < 8; v++) begin
            logic [7:0] lv = VECS[v][15:8];
            logic [7:0] dv = VECS[v][7:0];
            logic [7:0] m = dv & (8'hFF >> (3 - int'(lv[5:4])));
            lcr = lv;
            @(negedge clk);
            fork
                capture(lv, dv, "R1 R3 R4 R5 line frame");
                put(dv);
            join
            wait_rx();
            take(d, pe, fe);
            chk(d == m, "R13 R1 received data", d, m);
            chk(!pe && !fe, "R5 R4 R3 loopback flags", {pe, fe}, 0);
            repeat (64) @(negedge clk);
        end

        // R2 stop-bit count seen as start-to-start spacing
        do_reset();
        gap(8'h39, 352, "R2 two stop gap");
        do_reset();
        gap(8'h31, 320, "R2 one stop gap");

        // R6 parity mismatch, even mode (0x3C has even ones, parity 1 is wrong)
        do_reset(); lcr = 8'h37;
        drive(8'h3C, 8, 1, 1, 1, 0, 1);
        wait_rx(); take(d, pe, fe);
        chk(d == 8'h3C && pe && !fe, "R6 parity error", {fe, pe, d}, {2'b01, 8'h3C});
        // R4 fixed-level 1 checked: sending 0 must flag
        lcr = 8'hB3;
        drive(8'h00, 8, 1, 0, 1, 0, 1);
        wait_rx(); take(d, pe, fe);
        chk(pe && !fe, "R4 fixed parity check", {fe, pe}, 2'b01);
        // R5 parity disabled: no parity slot expected, no error
        lcr = 8'hB5;
        drive(8'h81, 8, 0, 0, 1, 0, 1);
        wait_rx(); take(d, pe, fe);
        chk(d == 8'h81 && !pe && !fe, "R5 no parity rx", {fe, pe, d}, {2'b00, 8'h81});
        // R7 low first stop bit
        lcr = 8'h31;
        drive(8'h5A, 8, 0, 0, 0, 0, 1);
        wait_rx(); take(d, pe, fe);
        chk(d == 8'h5A && fe && !pe, "R7 framing error", {fe, pe, d}, {2'b10, 8'h5A});
        // R8 low second stop bit in two-stop mode is not checked
        lcr = 8'h39;
        drive(8'hC3, 8, 0, 0, 1, 1, 0);
        chk(!rx_empty, "R8 char present", rx_empty, 0);
        take(d, pe, fe);
        chk(d == 8'hC3 && !fe, "R8 second stop ignored", {fe, d}, {1'b0, 8'hC3});

        // R9 short low glitch yields nothing
        do_reset(); lcr = 8'h31; loop = 1'b0;
        @(negedge clk); drv = 1'b0; repeat (8) @(negedge clk); drv = 1'b1;
        repeat (600) @(negedge clk);
        chk(rx_empty, "R9 glitch rejected", rx_empty, 1);

        // R10 queue mode: fill transmit queue, then receive queue
        loop = 1'b1; lcr = 8'h31; do_reset();
        for (int i = 0; i < 17; i++) put(8'(i));
        chk(tx_full, "R10 tx full at 16", tx_full, 1);
        put(8'hEE);
        repeat (6000) @(negedge clk);
        chk(rx_full, "R10 rx full at 16", rx_full, 1);
        for (int i = 0; i < 16; i++) begin
            take(d, pe, fe);
            chk(d == 8'(i), "R10 order", d, i);
        end
        chk(rx_empty, "R10 overflow dropped", rx_empty, 1);

        // R11 holding mode on transmit: third write dropped
        lcr = 8'h30; do_reset();
        put(8'h11); put(8'h22);
        chk(tx_full, "R11 tx full at one", tx_full, 1);
        put(8'h33);
        wait_rx(); take(d, pe, fe);
        chk(d == 8'h11, "R11 first char", d, 8'h11);
        wait_rx(); take(d, pe, fe);
        chk(d == 8'h22, "R11 second char", d, 8'h22);
        repeat (1000) @(negedge clk);
        chk(rx_empty, "R11 write while full dropped", rx_empty, 1);
        // R11 holding mode on receive: second frame dropped
        drive(8'h44, 8, 0, 0, 1, 0, 1);
        chk(rx_full, "R11 rx full at one", rx_full, 1);
        drive(8'h55, 8, 0, 0, 1, 0, 1);
        take(d, pe, fe);
        chk(d == 8'h44, "R11 held char kept", d, 8'h44);
        chk(rx_empty, "R11 arriving frame dropped", rx_empty, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule